// File: doc/BRIEF.md
# TMDS Test Pattern Generator

This block sits between a TMDS encoder and the serialiser and decides what 10-bit symbol goes out on each character clock. A three-bit select field picks one of four sources: a constant zero, the encoder's own symbol passed straight through, a pseudo-random bit sequence, or a user-programmed 80-bit pattern played back ten bits at a time. The registered result is presented one clock after its inputs.

The pseudo-random engine offers four polynomials (lengths 7, 11, 15 and 31). It emits 1, 8 or 10 fresh bits per cycle, or nothing when idle. The pattern engine holds each of its eight 10-bit slices for a programmable 1 to 8 cycles before moving to the next slice. Each engine has its own enable. A disabled engine returns to its start point, so enabling it again always replays the sequence from the beginning. Both engines keep running while enabled, whichever source is selected.

Top module: `tmds_test_pattern_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `tmds_out` is zero.
- R2: `out_sel` 3'b000 gives zero. Any code other than 000, 001, 010 or 100 also gives zero.
- R3: With `out_sel` 3'b001, `tmds_out` equals the `tmds_in` value from one clock earlier.
- R4: `prbs_mode` picks the polynomial: 0 = x^11+x^9+1, 1 = x^15+x^14+1, 2 = x^7+x^6+1, 3 = x^31+x^28+1. For length L and inner tap T, each new bit is state[L-1] XOR state[T-1]. That bit is shifted into state bit 0. The state is all ones at the first cycle of an enabled run.
- R5: `prbs_width` sets how many new bits come out per cycle: 0 = none (output zero), 1 = 8 bits, 2 = 1 bit, 3 = 10 bits. The first generated bit lands in `tmds_out[0]`. The state advances by exactly that many bits each cycle.
- R6: In 1-bit and 8-bit widths, the `tmds_out` bits above the generated ones are zero.
- R7: With `prbs_en` low, selecting 3'b010 gives zero. The next enabled run starts again from the all-ones state.
- R8: With `out_sel` 3'b100, slice k is `shift_pattern[10k+9:10k]`. Slices are emitted in the order k = 0..7, then wrap back to 0.
- R9: Each slice is held for `shift_repeat`+1 consecutive cycles.
- R10: With `shift_en` low, selecting 3'b100 gives zero. The next enabled run restarts at slice 0 with a fresh hold count.
- R11: Each engine advances every cycle it is enabled, whether or not it is the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_sel | input | 3 | Output source select |
| prbs_en | input | 1 | Pseudo-random engine enable |
| prbs_mode | input | 2 | Polynomial choice |
| prbs_width | input | 2 | Bits generated per cycle |
| shift_en | input | 1 | Pattern engine enable |
| shift_repeat | input | 3 | Slice hold count minus one |
| shift_pattern | input | 80 | Programmed 80-bit pattern |
| tmds_in | input | 10 | Symbol from the TMDS encoder |
| tmds_out | output | 10 | Registered test symbol |

## Verification
The case that needs care is both engines stepping in the same cycle while the select toggles between them. Either engine could wrongly stall while it is not the one being shown. The bench enables the pseudo-random engine and the pattern engine together, then flips `out_sel` between 010 and 100 every cycle. It keeps independent reference models of both engines, advances both on every cycle, and compares each output against the model of whichever source was selected. An engine that pauses while hidden shows up as a mismatch on the next cycle it is selected.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    localparam logic [2:0] SEL_ZERO  = 3'b000;
    localparam logic [2:0] SEL_PASS  = 3'b001;
    localparam logic [2:0] SEL_PRBS  = 3'b010;
    localparam logic [2:0] SEL_SHIFT = 3'b100;

    typedef enum logic [1:0] {
        POLY_11 = 2'd0,
        POLY_15 = 2'd1,
        POLY_7  = 2'd2,
        POLY_31 = 2'd3
    } poly_e;

    typedef enum logic [1:0] {
        WID_IDLE = 2'd0,
        WID_8    = 2'd1,
        WID_1    = 2'd2,
        WID_10   = 2'd3
    } width_e;
endpackage

// File: rtl/tpg_prbs.sv
module tpg_prbs
    import tpg_pkg::*;
#(
    parameter int SYM_W  = 10,
    parameter int LFSR_W = 31,
    parameter int NARROW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       mode,
    input  logic [1:0]       width,
    output logic [SYM_W-1:0] sym
);
    localparam int IW = $clog2(LFSR_W);

    typedef struct packed {
        logic [LFSR_W-1:0] state;
    } prbs_st_t;

    prbs_st_t st_d, st_q;
    logic [SYM_W-1:0]  sym_c;
    logic [IW-1:0]     hi_idx, tap_idx;
    logic [LFSR_W-1:0] walk;
    logic              fb;
    int                nbits;

    always_comb begin
        case (mode)
            POLY_11: begin hi_idx = IW'(10); tap_idx = IW'(8);  end
            POLY_15: begin hi_idx = IW'(14); tap_idx = IW'(13); end
            POLY_7:  begin hi_idx = IW'(6);  tap_idx = IW'(5);  end
            default: begin hi_idx = IW'(30); tap_idx = IW'(27); end
        endcase
        case (width)
            WID_8:   nbits = NARROW;
            WID_1:   nbits = 1;
            WID_10:  nbits = SYM_W;
            default: nbits = 0;
        endcase
        walk  = st_q.state;
        sym_c = '0;
        fb    = 1'b0;
        for (int i = 0; i < SYM_W; i++) begin
            if (i < nbits) begin
                fb       = walk[hi_idx] ^ walk[tap_idx];
                sym_c[i] = fb;
                walk     = {walk[LFSR_W-2:0], fb};
            end
        end
        st_d.state = en ? walk : '1;
        sym        = en ? sym_c : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: '1};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tpg_shift.sv
module tpg_shift #(
    parameter int SYM_W   = 10,
    parameter int NUM_SYM = 8,
    parameter int REP_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [REP_W-1:0]         rep,
    input  logic [NUM_SYM*SYM_W-1:0] pattern,
    output logic [SYM_W-1:0]         sym
);
    localparam int IDX_W = $clog2(NUM_SYM);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [REP_W-1:0] cnt;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.idx = '0;
            st_d.cnt = '0;
        end else if (st_q.cnt == rep) begin
            st_d.cnt = '0;
            st_d.idx = (int'(st_q.idx) == NUM_SYM-1) ? '0 : st_q.idx + 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        sym = en ? pattern[int'(st_q.idx)*SYM_W +: SYM_W] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmds_test_pattern_gen.sv
module tmds_test_pattern_gen
    import tpg_pkg::*;
#(
    parameter int SYM_W   = 10,
    parameter int NUM_SYM = 8,
    parameter int REP_W   = 3,
    parameter int LFSR_W  = 31
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               out_sel,
    input  logic                     prbs_en,
    input  logic [1:0]               prbs_mode,
    input  logic [1:0]               prbs_width,
    input  logic                     shift_en,
    input  logic [REP_W-1:0]         shift_repeat,
    input  logic [NUM_SYM*SYM_W-1:0] shift_pattern,
    input  logic [SYM_W-1:0]         tmds_in,
    output logic [SYM_W-1:0]         tmds_out
);
    typedef struct packed {
        logic [SYM_W-1:0] out;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic [SYM_W-1:0] prbs_sym, shift_sym;

    tpg_prbs #(.SYM_W(SYM_W), .LFSR_W(LFSR_W)) u_prbs (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (prbs_en),
        .mode  (prbs_mode),
        .width (prbs_width),
        .sym   (prbs_sym)
    );

    tpg_shift #(.SYM_W(SYM_W), .NUM_SYM(NUM_SYM), .REP_W(REP_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (shift_en),
        .rep     (shift_repeat),
        .pattern (shift_pattern),
        .sym     (shift_sym)
    );

    always_comb begin
        case (out_sel)
            SEL_PASS:  st_d.out = tmds_in;
            SEL_PRBS:  st_d.out = prbs_sym;
            SEL_SHIFT: st_d.out = shift_sym;
            default:   st_d.out = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmds_out = st_q.out;
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
    parameter int SYM_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       out_sel,
    input logic             prbs_en,
    input logic [1:0]       prbs_width,
    input logic             shift_en,
    input logic [SYM_W-1:0] tmds_in,
    input logic [SYM_W-1:0] tmds_out
);
    always_comb begin
        if (!rst_n) assert_zero_in_reset_R1: assert (tmds_out == '0);
    end

    assert_zero_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel != 3'b001 && out_sel != 3'b010 && out_sel != 3'b100) |=> tmds_out == '0);

    assert_passthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'b001) |=> tmds_out == $past(tmds_in));

    assert_idle_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'b010 && prbs_width == 2'd0) |=> tmds_out == '0);

    assert_narrow_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'b010 && prbs_width == 2'd2) |=> tmds_out[SYM_W-1:1] == '0);

    assert_narrow_eight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'b010 && prbs_width == 2'd1) |=> tmds_out[SYM_W-1:8] == '0);

    assert_prbs_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'b010 && !prbs_en) |=> tmds_out == '0);

    assert_shift_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'b100 && !shift_en) |=> tmds_out == '0);
endmodule

bind tmds_test_pattern_gen tpg_checker #(.SYM_W(SYM_W)) u_chk (.*);

// File: tb/tmds_test_pattern_gen_tb.sv
module tmds_test_pattern_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  out_sel = '0;
    logic        prbs_en = 1'b0;
    logic [1:0]  prbs_mode = '0;
    logic [1:0]  prbs_width = '0;
    logic        shift_en = 1'b0;
    logic [2:0]  shift_repeat = '0;
    logic [79:0] shift_pattern = '0;
    logic [9:0]  tmds_in = '0;
    logic [9:0]  tmds_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmds_test_pattern_gen u_dut (
        .clk(clk), .rst_n(rst_n), .out_sel(out_sel), .prbs_en(prbs_en),
        .prbs_mode(prbs_mode), .prbs_width(prbs_width), .shift_en(shift_en),
        .shift_repeat(shift_repeat), .shift_pattern(shift_pattern),
        .tmds_in(tmds_in), .tmds_out(tmds_out)
    );

    task automatic check(string req, logic [9:0] act, logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int bits_for(logic [1:0] w);
        case (w)
            2'd1: return 8;
            2'd2: return 1;
            2'd3: return 10;
            default: return 0;
        endcase
    endfunction

    function automatic logic [9:0] ref_prbs(logic [1:0] mode, int n, ref logic [30:0] s);
        int len, tp;
        logic [9:0] r = '0;
        logic b;
        case (mode)
            2'd0: begin len = 11; tp = 9;  end
            2'd1: begin len = 15; tp = 14; end
            2'd2: begin len = 7;  tp = 6;  end
            default: begin len = 31; tp = 28; end
        endcase
        for (int k = 0; k < n; k++) begin
            b = s[len-1] ^ s[tp-1];
            r[k] = b;
            s = {s[29:0], b};
        end
        return r;
    endfunction

    task automatic quiesce();
        prbs_en = 1'b0; shift_en = 1'b0; out_sel = 3'b000;
        tick();
    endtask

    task automatic t_reset();
        check("R1 in reset", tmds_out, 10'h0);
        rst_n = 1'b1;
        tick();
        check("R1 after release", tmds_out, 10'h0);
    endtask

    task automatic t_select();
        tmds_in = 10'h2B7; out_sel = 3'b000; tick();
        check("R2 zero select", tmds_out, 10'h0);
        foreach (tmds_in[i]) begin end
        for (int v = 0; v < 4; v++) begin
            logic [9:0] val = 10'(v * 10'h15B + 10'h0A3);
            tmds_in = val; out_sel = 3'b001; tick();
            check("R3 passthrough", tmds_out, val);
        end
        tmds_in = 10'h3FF;
        for (int c = 0; c < 8; c++) begin
            if (c == 3 || c == 5 || c == 6 || c == 7) begin
                out_sel = 3'(c); tick();
                check("R2 undefined code", tmds_out, 10'h0);
            end
        end
    endtask

    task automatic t_prbs(logic [1:0] mode, logic [1:0] w, int n, string req);
        logic [30:0] s = '1;
        logic [9:0] exp;
        prbs_mode = mode; prbs_width = w; prbs_en = 1'b1; out_sel = 3'b010;
        for (int c = 0; c < n; c++) begin
            exp = ref_prbs(mode, bits_for(w), s);
            tick();
            check(req, tmds_out, exp);
        end
        quiesce();
    endtask

    task automatic t_prbs_restart();
        logic [30:0] s = '1;
        logic [9:0] exp;
        prbs_mode = 2'd0; prbs_width = 2'd3; prbs_en = 1'b1; out_sel = 3'b010;
        for (int c = 0; c < 5; c++) tick();
        prbs_en = 1'b0; tick();
        check("R7 disabled output", tmds_out, 10'h0);
        prbs_en = 1'b1;
        for (int c = 0; c < 3; c++) begin
            exp = ref_prbs(2'd0, 10, s);
            tick();
            check("R7 restart from seed", tmds_out, exp);
        end
        quiesce();
    endtask

    function automatic logic [9:0] slice(int k);
        return shift_pattern[k*10 +: 10];
    endfunction

    task automatic t_shift(logic [2:0] rep);
        shift_repeat = rep; shift_en = 1'b1; out_sel = 3'b100;
        for (int c = 0; c < 9 * (int'(rep) + 1); c++) begin
            tick();
            check(rep == 0 ? "R8 slice order" : "R9 hold count", tmds_out,
                  slice((c / (int'(rep) + 1)) % 8));
        end
        quiesce();
    endtask

    task automatic t_shift_restart();
        shift_repeat = 3'd1; shift_en = 1'b1; out_sel = 3'b100;
        for (int c = 0; c < 5; c++) tick();
        shift_en = 1'b0; tick();
        check("R10 disabled output", tmds_out, 10'h0);
        shift_en = 1'b1;
        for (int c = 0; c < 4; c++) begin
            tick();
            check("R10 restart at slice 0", tmds_out, slice(c / 2));
        end
        quiesce();
    endtask

    task automatic t_concurrent();
        logic [30:0] s = '1;
        logic [9:0] pexp;
        prbs_mode = 2'd2; prbs_width = 2'd1; prbs_en = 1'b1;
        shift_repeat = 3'd0; shift_en = 1'b1;
        for (int c = 0; c < 20; c++) begin
            pexp = ref_prbs(2'd2, 8, s);
            out_sel = (c % 2 == 0) ? 3'b010 : 3'b100;
            tick();
            check("R11 both engines advance", tmds_out,
                  (c % 2 == 0) ? pexp : slice(c % 8));
        end
        quiesce();
    endtask

    initial begin
        for (int k = 0; k < 8; k++) shift_pattern[k*10 +: 10] = 10'(10'h1C3 ^ (k * 89));
        @(negedge clk); @(negedge clk);
        t_reset();
        t_select();
        t_prbs(2'd0, 2'd3, 12, "R4 poly 11");
        t_prbs(2'd1, 2'd3, 12, "R4 poly 15");
        t_prbs(2'd2, 2'd3, 12, "R4 poly 7");
        t_prbs(2'd3, 2'd3, 12, "R4 poly 31");
        t_prbs(2'd1, 2'd1, 12, "R5 R6 width 8");
        t_prbs(2'd3, 2'd2, 40, "R5 R6 width 1");
        t_prbs(2'd0, 2'd0, 4,  "R5 idle width");
        t_prbs_restart();
        t_shift(3'd0);
        t_shift(3'd2);
        t_shift(3'd7);
        t_shift_restart();
        t_concurrent();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule